// File: doc/BRIEF.md
# Floating-Point Exception Status Accumulator

This block holds the exception state of a floating-point unit. Each time an operation completes, the unit presents the raised exception flags, the instruction's logical address and a two-bit instruction class on a single-cycle strobe. The block keeps two registers. The first is a per-operation exception byte, which the latest arithmetic operation overwrites. The second is a sticky accrued byte, which gathers derived combinations of those flags so that software can poll once at the end of a sequence of operations.

A separate instruction address register records where the most recent trapping instruction lives, so a handler can find the instruction that faulted. The class input tells the block which registers the instruction may touch. Register-move instructions touch neither the status nor the address.

Software reads either register through a select input and writes either one through a write port. A combinational trap-request output combines the incoming exception flags with an enable mask in the same cycle as the strobe.

Top module: `fp_exc_status`

## Requirements
- R1: After reset is released, the status word and the address register both read zero and trap_o is low.
- R2: With rd_sel_i=0 the status word is read. Bits 15:8 hold the exception byte: branch-unordered 15, signaling-NaN 14, operand-error 13, overflow 12, underflow 11, divide-by-zero 10, inexact-result 9, inexact-operand 8. op_flags_i uses the same order in bits 7:0. Bits 7:3 hold the accrued byte: invalid 7, overflow 6, underflow 5, divide-by-zero 4, inexact 3. Bits 2:0 and all bits above 15 read zero and ignore writes. With rd_sel_i=1 the address register is read.
- R3: When an updating operation is accepted, the accrued bits become old OR terms derived from op_flags_i. The invalid term is signaling-NaN OR operand-error. The overflow term is overflow. The underflow term is underflow AND inexact-result. The divide-by-zero term is divide-by-zero. The inexact term is inexact-operand OR inexact-result OR overflow. Accrued bits are cleared only by a status write.
- R4: For op_class_i 0 (trapping arithmetic) and 1 (non-trapping arithmetic), an accepted operation replaces the exception byte with op_flags_i on the next edge.
- R5: For op_class_i 0 only, an accepted operation loads op_addr_i into the address register on the next edge.
- R6: For op_class_i 2 (control/status/address register move) and 3 (multi-register move), the exception byte, the accrued byte and the address register stay unchanged.
- R7: wr_sel_i=0 writes the status word and wr_sel_i=1 writes the address register. When a write and an operation arrive in the same cycle, the written register takes the write data. The other register still takes the operation's update.
- R8: trap_o is high in the strobe cycle exactly when op_valid_i is high, op_class_i is 0 or 1, and (op_flags_i AND trap_en_i) is nonzero.
- R9: trap_o does not depend on the accrued byte or on a status write: a write never raises a trap and never suppresses one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation-complete strobe |
| op_class_i | input | 2 | Instruction class (0 trap arith, 1 quiet arith, 2 register move, 3 multi move) |
| op_flags_i | input | 8 | Exception flags raised by the operation |
| op_addr_i | input | DATA_W | Logical address of the instruction |
| trap_en_i | input | 8 | Trap enable mask, same order as op_flags_i |
| wr_en_i | input | 1 | Software write strobe |
| wr_sel_i | input | 1 | Write target: 0 status, 1 address |
| wr_data_i | input | DATA_W | Write data |
| rd_sel_i | input | 1 | Read select: 0 status, 1 address |
| rd_data_o | output | DATA_W | Read data |
| trap_o | output | 1 | Trap request |

## Verification
The bench builds the block with the default DATA_W of 32. This exercises the zero padding above bit 15 of the status word, and it lets random full-width writes and addresses show whether any upper status bit leaks into the read path. Random flag bytes and trap masks cover each accrual term, including underflow with and without inexact-result. Random class choices and random write collisions reach the write-wins cases for both registers.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int EXC_W  = 8;
  localparam int ACC_W  = 5;
  localparam int STAT_W = 16;
  localparam int EXC_LSB = 8;
  localparam int ACC_LSB = 3;

  // exception byte bit positions
  localparam int E_BSUN  = 7;
  localparam int E_SNAN  = 6;
  localparam int E_OPERR = 5;
  localparam int E_OVFL  = 4;
  localparam int E_UNFL  = 3;
  localparam int E_DZ    = 2;
  localparam int E_INEX2 = 1;
  localparam int E_INEX1 = 0;

  // accrued byte bit positions
  localparam int A_IOP  = 4;
  localparam int A_OVFL = 3;
  localparam int A_UNFL = 2;
  localparam int A_DZ   = 1;
  localparam int A_INEX = 0;

  typedef enum logic [1:0] {
    CLS_TRAP_ARITH  = 2'd0,
    CLS_QUIET_ARITH = 2'd1,
    CLS_REG_MOVE    = 2'd2,
    CLS_MULTI_MOVE  = 2'd3
  } op_class_e;

  function automatic logic [ACC_W-1:0] accrue_terms(input logic [EXC_W-1:0] e);
    logic [ACC_W-1:0] t;
    t[A_IOP]  = e[E_SNAN] | e[E_OPERR];
    t[A_OVFL] = e[E_OVFL];
    t[A_UNFL] = e[E_UNFL] & e[E_INEX2];
    t[A_DZ]   = e[E_DZ];
    t[A_INEX] = e[E_INEX1] | e[E_INEX2] | e[E_OVFL];
    return t;
  endfunction
endpackage

// File: rtl/fpx_class_decode.sv
module fpx_class_decode
  import fpx_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] class_i,
  output logic       upd_exc_o,
  output logic       load_addr_o
);
  op_class_e cls;
  assign cls = op_class_e'(class_i);

  always_comb begin
    upd_exc_o   = 1'b0;
    load_addr_o = 1'b0;
    if (valid_i) begin
      unique case (cls)
        CLS_TRAP_ARITH: begin
          upd_exc_o   = 1'b1;
          load_addr_o = 1'b1;
        end
        CLS_QUIET_ARITH: upd_exc_o = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
  import fpx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [EXC_W-1:0] wr_exc_i,
  input  logic [ACC_W-1:0] wr_acc_i,
  input  logic             upd_i,
  input  logic [EXC_W-1:0] flags_i,
  output logic [EXC_W-1:0] exc_o,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] terms;
  assign terms = accrue_terms(flags_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    exc_o <= '0;
    else if (wr_i)  exc_o <= wr_exc_i;
    else if (upd_i) exc_o <= flags_i;
  end

  for (genvar b = 0; b < ACC_W; b++) begin : g_acc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    acc_o[b] <= 1'b0;
      else if (wr_i)  acc_o[b] <= wr_acc_i[b];
      else if (upd_i) acc_o[b] <= acc_o[b] | terms[b];
    end
  end
endmodule

// File: rtl/fpx_addr_reg.sv
module fpx_addr_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         load_i,
  input  logic [W-1:0] addr_i,
  output logic [W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (wr_i)   addr_o <= wr_data_i;
    else if (load_i) addr_o <= addr_i;
  end
endmodule

// File: rtl/fpx_trap_gen.sv
module fpx_trap_gen #(
  parameter int N = 8
) (
  input  logic         arm_i,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  output logic         trap_o
);
  logic [N-1:0] hit;
  for (genvar b = 0; b < N; b++) begin : g_hit
    assign hit[b] = flags_i[b] & en_i[b];
  end
  assign trap_o = arm_i & (|hit);
endmodule

// File: rtl/fp_exc_status.sv
module fp_exc_status
  import fpx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [1:0]        op_class_i,
  input  logic [7:0]        op_flags_i,
  input  logic [DATA_W-1:0] op_addr_i,
  input  logic [7:0]        trap_en_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              trap_o
);
  localparam int PAD_W = DATA_W - STAT_W;

  logic             upd_exc, load_addr, stat_wr, addr_wr;
  logic [EXC_W-1:0] exc_q;
  logic [ACC_W-1:0] acc_q;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] stat_word;
  logic unused_wr_bits;

  assign stat_wr = wr_en_i & ~wr_sel_i;
  assign addr_wr = wr_en_i &  wr_sel_i;
  assign unused_wr_bits = ^{wr_data_i[DATA_W-1:STAT_W], wr_data_i[ACC_LSB-1:0]};

  fpx_class_decode i_decode (
    .valid_i    (op_valid_i),
    .class_i    (op_class_i),
    .upd_exc_o  (upd_exc),
    .load_addr_o(load_addr)
  );

  fpx_status_reg i_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (stat_wr),
    .wr_exc_i(wr_data_i[EXC_LSB +: EXC_W]),
    .wr_acc_i(wr_data_i[ACC_LSB +: ACC_W]),
    .upd_i   (upd_exc),
    .flags_i (op_flags_i),
    .exc_o   (exc_q),
    .acc_o   (acc_q)
  );

  fpx_addr_reg #(.W(DATA_W)) i_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (addr_wr),
    .wr_data_i(wr_data_i),
    .load_i   (load_addr),
    .addr_i   (op_addr_i),
    .addr_o   (addr_q)
  );

  fpx_trap_gen #(.N(EXC_W)) i_trap (
    .arm_i  (upd_exc),
    .flags_i(op_flags_i),
    .en_i   (trap_en_i),
    .trap_o (trap_o)
  );

  assign stat_word = {{PAD_W{1'b0}}, exc_q, acc_q, {ACC_LSB{1'b0}}};
  assign rd_data_o = rd_sel_i ? addr_q : stat_word;
endmodule

// File: rtl/fpx_status_chk.sv
module fpx_status_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [1:0]        op_class_i,
  input logic [7:0]        op_flags_i,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rd_sel_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              trap_o,
  input logic [7:0]        exc_q,
  input logic [4:0]        acc_q,
  input logic [DATA_W-1:0] addr_q
);
  logic swr, awr;
  assign swr = wr_en_i & ~wr_sel_i;
  assign awr = wr_en_i &  wr_sel_i;

  // R3: accrued bits never fall without a status write
  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swr |=> ((acc_q & $past(acc_q)) == $past(acc_q)));

  // R2: low status bits always read zero
  a_r2_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_sel_i |-> (rd_data_o[2:0] == 3'b000));

  // R4: arithmetic overwrites exception byte
  a_r4_exc_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !op_class_i[1] && !swr) |=> (exc_q == $past(op_flags_i)));

  // R6: register moves leave both registers alone
  a_r6_move_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_class_i[1] && !wr_en_i) |=> ($stable(exc_q) && $stable(acc_q) && $stable(addr_q)));

  // R7: software write wins over same-cycle update
  a_r7_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awr |=> (addr_q == $past(wr_data_i)));

  // R8: no trap without a strobe
  a_r8_trap_needs_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (op_valid_i && !op_class_i[1]));
endmodule

bind fp_exc_status fpx_status_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_valid_i(op_valid_i),
  .op_class_i(op_class_i),
  .op_flags_i(op_flags_i),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .rd_sel_i  (rd_sel_i),
  .rd_data_o (rd_data_o),
  .trap_o    (trap_o),
  .exc_q     (exc_q),
  .acc_q     (acc_q),
  .addr_q    (addr_q)
);

// File: tb/test_fp_exc_status.sv
module test_fp_exc_status;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [1:0]    op_class = '0;
  logic [7:0]    op_flags = '0;
  logic [DW-1:0] op_addr = '0;
  logic [7:0]    trap_en = '0;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_sel = 1'b0;
  logic [DW-1:0] rd_data;
  logic          trap;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0]    m_exc = '0;
  logic [4:0]    m_acc = '0;
  logic [DW-1:0] m_addr = '0;

  always #4 clk = ~clk;

  fp_exc_status #(.DATA_W(DW)) i_fp_exc_status (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_class_i(op_class),
    .op_flags_i(op_flags), .op_addr_i(op_addr), .trap_en_i(trap_en),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .trap_o(trap)
  );

  // flags: 7 bsun 6 snan 5 operr 4 ovfl 3 unfl 2 dz 1 inex2 0 inex1
  function automatic logic [4:0] terms(input logic [7:0] f);
    return {f[6] | f[5], f[4], f[3] & f[1], f[2], f[0] | f[1] | f[4]};
  endfunction

  function automatic logic [DW-1:0] stat_word(input logic [7:0] e, input logic [4:0] a);
    return {16'h0, e, a, 3'b000};
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_both(input string tag);
    rd_sel = 1'b0; #1;
    check({tag, " status"}, rd_data, stat_word(m_exc, m_acc));
    rd_sel = 1'b1; #1;
    check({tag, " addr"}, rd_data, m_addr);
  endtask

  // drive at negedge, check trap in-cycle, clock, update model, read back
  task automatic step(input logic v, input logic [1:0] c, input logic [7:0] f,
                      input logic [DW-1:0] a, input logic [7:0] en,
                      input logic we, input logic ws, input logic [DW-1:0] wd,
                      input string tag);
    logic exp_trap;
    @(negedge clk);
    op_valid = v; op_class = c; op_flags = f; op_addr = a; trap_en = en;
    wr_en = we; wr_sel = ws; wr_data = wd;
    #1;
    exp_trap = v && (c < 2) && ((f & en) != 0);
    check({tag, " R8 R9 trap"}, {31'b0, trap}, {31'b0, exp_trap});
    @(posedge clk);
    if (we && !ws) begin m_exc = wd[15:8]; m_acc = wd[7:3]; end
    else if (v && c < 2) begin m_exc = f; m_acc = m_acc | terms(f); end
    if (we && ws) m_addr = wd;
    else if (v && c == 2'd0) m_addr = a;
    @(negedge clk);
    op_valid = 1'b0; wr_en = 1'b0;
    read_both(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    rd_sel = 1'b0; #1;
    check("R1 reset status", rd_data, '0);
    rd_sel = 1'b1; #1;
    check("R1 reset addr", rd_data, '0);
    check("R1 reset trap", {31'b0, trap}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    read_both("R1 after release");

    // R3: underflow alone does not accrue underflow
    step(1, 0, 8'h08, 32'h1000, 8'h00, 0, 0, 0, "R3 unfl only");
    // R3: underflow with inexact-result accrues underflow and inexact
    step(1, 1, 8'h0A, 32'h2000, 8'h00, 0, 0, 0, "R3 unfl+inex2");
    // R3: overflow also sets inexact; R4 overwrite
    step(1, 0, 8'h10, 32'h3000, 8'h10, 0, 0, 0, "R3 R4 ovfl");
    // R3: snan and operr feed invalid; R5 address loads
    step(1, 0, 8'h40, 32'hCAFE_0004, 8'h00, 0, 0, 0, "R3 R5 snan");
    // R6: moves touch nothing
    step(1, 2, 8'hFF, 32'hDEAD_0000, 8'hFF, 0, 0, 0, "R6 reg move");
    step(1, 3, 8'hFF, 32'hBEEF_0000, 8'hFF, 0, 0, 0, "R6 multi move");
    // R5: quiet arithmetic keeps address
    step(1, 1, 8'h00, 32'h5555_0000, 8'h00, 0, 0, 0, "R5 quiet no load");
    // R2: pad bits ignore writes
    step(0, 0, 8'h00, 0, 8'h00, 1, 0, 32'hFFFF_FFFF, "R2 write all ones");
    // R9: accrued all set, flags zero, mask full: no trap
    step(1, 1, 8'h00, 0, 8'hFF, 0, 0, 0, "R9 no trap from accrued");
    // R3: sticky clear by write only
    step(0, 0, 8'h00, 0, 8'h00, 1, 0, 32'h0000_0000, "R3 clear by write");
    // R7 R9: status write collides with trapping op
    step(1, 0, 8'h04, 32'h7777_0000, 8'h04, 1, 0, 32'h0000_8018, "R7 R9 stat collide");
    // R7: address write collides with trapping op
    step(1, 0, 8'h20, 32'h1111_0000, 8'h20, 1, 1, 32'h2222_0000, "R7 addr collide");

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] f;
      f = 8'($urandom);
      if ($urandom_range(0, 3) == 0) f = '0;
      step($urandom_range(0, 4) != 0, 2'($urandom), f, $urandom, 8'($urandom),
           $urandom_range(0, 7) == 0, 1'($urandom), $urandom, "R2 R3 R4 R5 R6 R7 random");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule